// File: doc/BRIEF.md
# Best-state Viterbi decoder

This block is a hard-decision Viterbi decoder for a rate-1/2 convolutional code with constraint length 3, which gives four trellis states. It accepts one 2-bit received symbol on each clock where the symbol strobe is high. A branch metric unit scores each symbol against the four possible branch symbols. An add-compare-select stage then keeps one survivor per state and writes its choice into a survivor memory that holds one decoding window.

Every WIN_LEN accepted symbols (12 by default) close a window. A winner-take-all stage picks the state whose path metric is highest. Traceback starts from that state and not from a fixed state, which is why a window of about four constraint lengths is enough. The window's decoded bits then leave the block oldest-first, one per clock, each marked by a valid pulse. Path metrics carry over from one window to the next and are never cleared between windows.

Top module: `viterbi_bs_dec`

## Requirements
- R1: Encoder convention. The state is {newest input bit, older input bit}. Input bit u from state p moves to state {u, p[1]}. The transmitted symbol has bit 1 = parity({u,p} & 3'b111) and bit 0 = parity({u,p} & 3'b101). With no channel errors, the decoded bits equal the encoded bits.
- R2: A branch metric is the number of received bits that agree with the branch symbol (0 to 2). A candidate metric is the predecessor's metric plus the branch metric, and the higher candidate survives. On a tie, the predecessor with the lower state number wins (predecessor {ns[0],0} before {ns[0],1}).
- R3: After reset, state 0 holds metric INIT_BONUS (32), every other state holds 0, the window position is 0 and bit_valid_o is low.
- R4: Each WIN_LEN accepted symbols form one window. Traceback starts from the state with the highest metric after the window's last symbol, and the lowest state number wins a tie.
- R5: Each window yields exactly WIN_LEN bits, oldest first. bit_valid_o is high for WIN_LEN consecutive cycles, beginning with the cycle after the second rising edge that follows the acceptance of the window's last symbol.
- R6: Metrics are METRIC_W (8) bits wide. When every updated metric has its top bit set, the minimum is subtracted from all of them. Decisions stay the same as with unbounded metrics over arbitrarily long runs.
- R7: A clock with sym_valid_i low changes no metric, no survivor memory and no window position, whatever sym_i holds.
- R8: Symbols may be accepted on every clock. Back-to-back windows lose no output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_valid_i | input | 1 | Received symbol strobe |
| sym_i | input | 2 | Received hard-decision symbol pair |
| bit_valid_o | output | 1 | Decoded bit valid |
| bit_o | output | 1 | Decoded bit |

## Verification
Error-free streams of all zeros, all ones, alternating bits and pseudo-random bits show that decoding and the state convention are correct against the sent data, and that long runs keep decoding correctly through renormalisation. Streams with isolated single-bit errors and fully random received symbols are scored against a bench model with unbounded integer metrics. These separate survivor and best-state tie-breaking and the initial bias toward state 0 from plain decoding. Strobe gaps filled with junk symbols show that idle clocks are ignored, and one isolated window pins down the exact output timing and burst length.

// File: rtl/viterbi_bs_pkg.sv
package viterbi_bs_pkg;
  localparam int CONSTR_LEN = 3;
  localparam int MEM_BITS   = CONSTR_LEN - 1;
  localparam int NUM_STATES = 1 << MEM_BITS;
  localparam int SYM_W      = 2;
  localparam int NUM_SYMS   = 1 << SYM_W;
  localparam int METRIC_W   = 8;
  localparam logic [CONSTR_LEN-1:0] GEN_HI = 3'b111;
  localparam logic [CONSTR_LEN-1:0] GEN_LO = 3'b101;

  typedef logic [METRIC_W-1:0] metric_t;
  typedef logic [MEM_BITS-1:0] state_t;

  function automatic logic [SYM_W-1:0] branch_sym(input state_t prev, input logic bit_in);
    logic [CONSTR_LEN-1:0] taps;
    taps = {bit_in, prev};
    return {^(taps & GEN_HI), ^(taps & GEN_LO)};
  endfunction
endpackage

// File: rtl/viterbi_bs_bmu.sv
module viterbi_bs_bmu
  import viterbi_bs_pkg::*;
(
  input  logic [SYM_W-1:0]                 sym_i,
  output logic [NUM_SYMS-1:0][SYM_W-1:0]   bm_o
);
  for (genvar e = 0; e < NUM_SYMS; e++) begin : g_bm
    logic [SYM_W-1:0] agree;
    assign agree    = ~(sym_i ^ SYM_W'(e));
    assign bm_o[e]  = {1'b0, agree[1]} + {1'b0, agree[0]};
  end
endmodule

// File: rtl/viterbi_bs_acs.sv
module viterbi_bs_acs
  import viterbi_bs_pkg::*;
#(
  parameter int INIT_BONUS = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             valid_i,
  input  logic [NUM_SYMS-1:0][SYM_W-1:0]   bm_i,
  output metric_t [NUM_STATES-1:0]         metric_o,
  output logic [NUM_STATES-1:0]            dec_o
);
  metric_t [NUM_STATES-1:0] metric_q, sum_d, metric_d;
  logic    [NUM_STATES-1:0] top_q, top_d;
  metric_t                  floor_d;

  for (genvar ns = 0; ns < NUM_STATES; ns++) begin : g_acs
    localparam int   P0 = (ns * 2) % NUM_STATES;
    localparam int   P1 = P0 + 1;
    localparam logic UB = 1'(ns >> (MEM_BITS - 1));
    logic [SYM_W-1:0] exp0, exp1;
    metric_t          cand0, cand1;
    assign exp0        = branch_sym(state_t'(P0), UB);
    assign exp1        = branch_sym(state_t'(P1), UB);
    assign cand0       = metric_q[P0] + metric_t'(bm_i[exp0]);
    assign cand1       = metric_q[P1] + metric_t'(bm_i[exp1]);
    // tie keeps lower predecessor
    assign dec_o[ns]   = cand1 > cand0;
    assign sum_d[ns]   = dec_o[ns] ? cand1 : cand0;
    assign top_d[ns]   = sum_d[ns][METRIC_W-1];
    assign top_q[ns]   = metric_q[ns][METRIC_W-1];
  end

  always_comb begin
    floor_d = sum_d[0];
    for (int s = 1; s < NUM_STATES; s++)
      if (sum_d[s] < floor_d) floor_d = sum_d[s];
  end

  always_comb begin
    for (int s = 0; s < NUM_STATES; s++)
      metric_d[s] = (&top_d) ? sum_d[s] - floor_d : sum_d[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_STATES; s++)
        metric_q[s] <= (s == 0) ? metric_t'(INIT_BONUS) : '0;
    end else if (valid_i) begin
      metric_q <= metric_d;
    end
  end

  assign metric_o = metric_q;

  AST_RENORM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&top_q)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(metric_q)); // R7
endmodule

// File: rtl/viterbi_bs_wta.sv
module viterbi_bs_wta
  import viterbi_bs_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  metric_t [NUM_STATES-1:0] metric_i,
  output state_t                   best_o
);
  always_comb begin
    best_o = '0;
    for (int s = 1; s < NUM_STATES; s++)
      if (metric_i[s] > metric_i[best_o]) best_o = state_t'(s);
  end

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_chk
    AST_BEST_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      metric_i[best_o] >= metric_i[s]); // R4
    AST_BEST_TIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (metric_i[best_o] == metric_i[s]) |-> (best_o <= state_t'(s))); // R4
  end
endmodule

// File: rtl/viterbi_bs_trace.sv
module viterbi_bs_trace
  import viterbi_bs_pkg::*;
#(
  parameter int WIN_LEN = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [NUM_STATES-1:0] dec_i,
  input  state_t                best_i,
  output logic                  bit_valid_o,
  output logic                  bit_o
);
  localparam int IDX_W = $clog2(WIN_LEN);
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic [NUM_STATES-1:0] dec_mem [WIN_LEN];
  logic [IDX_W-1:0]      win_idx_q;
  logic                  win_last, tb_go_q;
  logic [WIN_LEN-1:0]    tb_bits, out_q;
  logic [CNT_W-1:0]      cnt_q;

  assign win_last = win_idx_q == IDX_W'(WIN_LEN - 1);

  always_ff @(posedge clk_i) begin
    if (valid_i) dec_mem[win_idx_q] <= dec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_idx_q <= '0;
      tb_go_q   <= 1'b0;
    end else begin
      tb_go_q <= valid_i & win_last;
      if (valid_i) win_idx_q <= win_last ? '0 : win_idx_q + 1'b1;
    end
  end

  // traceback over the full window, newest step first
  always_comb begin
    state_t s;
    s = best_i;
    for (int j = WIN_LEN - 1; j >= 0; j--) begin
      tb_bits[j] = s[MEM_BITS-1];
      s = {s[MEM_BITS-2:0], dec_mem[j][s]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      cnt_q <= '0;
    end else if (tb_go_q) begin
      out_q <= tb_bits;
      cnt_q <= CNT_W'(WIN_LEN);
    end else if (cnt_q != '0) begin
      out_q <= out_q >> 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_valid_o = cnt_q != '0;
  assign bit_o       = out_q[0];

  AST_WIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_idx_q < IDX_W'(WIN_LEN)); // R4
  AST_LOAD_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_go_q |-> cnt_q <= CNT_W'(1)); // R8
  AST_BURST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_go_q |=> bit_valid_o && cnt_q == CNT_W'(WIN_LEN)); // R5
endmodule

// File: rtl/viterbi_bs_dec.sv
module viterbi_bs_dec
  import viterbi_bs_pkg::*;
#(
  parameter int WIN_LEN    = 12,
  parameter int INIT_BONUS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sym_valid_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             bit_valid_o,
  output logic             bit_o
);
  logic [NUM_SYMS-1:0][SYM_W-1:0] bm;
  metric_t [NUM_STATES-1:0]       metric;
  logic [NUM_STATES-1:0]          dec;
  state_t                         best;

  viterbi_bs_bmu u_bmu (
    .sym_i (sym_i),
    .bm_o  (bm)
  );

  viterbi_bs_acs #(.INIT_BONUS(INIT_BONUS)) u_acs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (sym_valid_i),
    .bm_i     (bm),
    .metric_o (metric),
    .dec_o    (dec)
  );

  viterbi_bs_wta u_wta (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .metric_i (metric),
    .best_o   (best)
  );

  viterbi_bs_trace #(.WIN_LEN(WIN_LEN)) u_trace (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (sym_valid_i),
    .dec_i       (dec),
    .best_i      (best),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o)
  );
endmodule

// File: tb/viterbi_bs_dec_test.sv
module viterbi_bs_dec_test;
  localparam int WIN   = 12;
  localparam int BONUS = 32;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sym_valid_i = 1'b0;
  logic [1:0] sym_i = 2'b00;
  logic       bit_valid_o, bit_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  int exp_q[$];
  int sent_q[$];
  int pm[4];
  bit dm[WIN][4];
  int widx;
  int enc_state;
  logic [15:0] lfsr = 16'hACE1;

  always #10ns clk_i = ~clk_i;

  viterbi_bs_dec #(.WIN_LEN(WIN), .INIT_BONUS(BONUS)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sym_valid_i(sym_valid_i), .sym_i(sym_i),
    .bit_valid_o(bit_valid_o), .bit_o(bit_o)
  );

  task automatic chk(string req, int act, int expv);
    vectors++;
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int par(int x);
    return $countones(x) & 1;
  endfunction

  function automatic int bsym(int p, int u);
    int r;
    r = (u << 2) | p;
    return par(r & 7) * 2 + par(r & 5);
  endfunction

  function automatic int next_lfsr_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[0]);
  endfunction

  function automatic int encode(int u);
    int s;
    s = bsym(enc_state, u);
    enc_state = (u << 1) | (enc_state >> 1);
    return s;
  endfunction

  // reference decoder with unbounded integer metrics
  task automatic model_step(int sym);
    int npm[4];
    int best;
    int st;
    int bits[WIN];
    for (int ns = 0; ns < 4; ns++) begin
      int u, p0, c0, c1;
      u  = ns >> 1;
      p0 = (ns << 1) & 3;
      c0 = pm[p0]     + 2 - $countones((sym ^ bsym(p0, u)) & 3);
      c1 = pm[p0 + 1] + 2 - $countones((sym ^ bsym(p0 + 1, u)) & 3);
      if (c1 > c0) begin npm[ns] = c1; dm[widx][ns] = 1'b1; end
      else         begin npm[ns] = c0; dm[widx][ns] = 1'b0; end
    end
    pm = npm;
    widx++;
    if (widx == WIN) begin
      widx = 0;
      best = 0;
      for (int s = 1; s < 4; s++) if (pm[s] > pm[best]) best = s;
      st = best;
      for (int j = WIN - 1; j >= 0; j--) begin
        bits[j] = st >> 1;
        st = ((st & 1) << 1) | int'(dm[j][st]);
      end
      for (int j = 0; j < WIN; j++) exp_q.push_back(bits[j]);
    end
  endtask

  task automatic send(int sym);
    @(negedge clk_i);
    sym_valid_i = 1'b1;
    sym_i = 2'(sym);
    model_step(sym);
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      sym_valid_i = 1'b0;
      sym_i = 2'($urandom_range(0, 3));
    end
  endtask

  task automatic send_clean(int u);
    sent_q.push_back(u);
    send(encode(u));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    sym_valid_i = 1'b0;
    pm[0] = BONUS; pm[1] = 0; pm[2] = 0; pm[3] = 0;
    widx = 0;
    enc_state = 0;
    exp_q.delete();
    sent_q.delete();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic drain(string req);
    gap(WIN + 4);
    chk(req, exp_q.size(), 0);
    chk(req, sent_q.size(), 0);
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && bit_valid_o) begin
      if (exp_q.size() == 0) chk("R5 unexpected bit", 1, 0);
      else chk("R2 R4 decoded bit vs model", int'(bit_o), exp_q.pop_front());
      if (sent_q.size() != 0) chk("R1 decoded bit vs sent", int'(bit_o), sent_q.pop_front());
    end
  end

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R3 reset state, R5 exact timing of one isolated window
    do_reset();
    @(negedge clk_i);
    chk("R3 valid low after reset", int'(bit_valid_o), 0);
    for (int i = 0; i < WIN; i++) send_clean(next_lfsr_bit());
    @(negedge clk_i);
    sym_valid_i = 1'b0;
    chk("R5 no output in traceback cycle", int'(bit_valid_o), 0);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk_i);
      chk("R5 burst valid", int'(bit_valid_o), 1);
    end
    @(negedge clk_i);
    chk("R5 burst ends", int'(bit_valid_o), 0);
    drain("R5 phase1 drained");

    // R1 R8 clean patterns back to back
    do_reset();
    for (int i = 0; i < 2 * WIN; i++) send_clean(0);
    for (int i = 0; i < 2 * WIN; i++) send_clean(1);
    for (int i = 0; i < 2 * WIN; i++) send_clean(i & 1);
    for (int i = 0; i < 4 * WIN; i++) send_clean(next_lfsr_bit());
    drain("R8 back-to-back drained");

    // R2 R4 isolated single-bit errors
    do_reset();
    for (int i = 0; i < 10 * WIN; i++) begin
      int s;
      s = encode(next_lfsr_bit());
      if (i % 9 == 4) s = s ^ ((i & 1) ? 2 : 1);
      send(s);
    end
    drain("R2 error phase drained");

    // R2 R3 R4 fully random received symbols, many ties
    do_reset();
    for (int i = 0; i < 20 * WIN; i++) send($urandom_range(0, 3));
    drain("R4 random phase drained");

    // R7 strobe gaps carrying junk symbols
    do_reset();
    for (int i = 0; i < 6 * WIN; i++) begin
      send_clean(next_lfsr_bit());
      if (i % 5 == 2) gap(1 + (i % 3));
    end
    drain("R7 gap phase drained");

    // R6 long runs crossing many renormalisations
    do_reset();
    for (int i = 0; i < 40 * WIN; i++) send_clean(next_lfsr_bit());
    drain("R6 clean long run drained");
    do_reset();
    for (int i = 0; i < 40 * WIN; i++) begin
      int s;
      s = encode(next_lfsr_bit());
      if (i % 11 == 6) s = s ^ 2;
      if (i % 23 == 17) s = $urandom_range(0, 3);
      send(s);
    end
    drain("R6 noisy long run drained");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule